// File: doc/BRIEF.md
# Page Hamming ECC Engine

The engine sits beside a NAND data path and watches every word that crosses it, eight or sixteen bits at a time. It folds the whole page into one Hamming code: a 16-bit parity word that XORs together the position of every set bit, and a 16-bit complementary word that XORs together the inverted positions. After a page program, software reads both words and stores them as four ECC bytes in the spare area.

On a page read, software streams the page and then sends the four stored ECC bytes straight after the last data word. The engine latches them and takes the syndrome against its own code. It then reports one of four outcomes: clean; a correctable single data bit, with its word and bit position; a single flipped bit inside the stored code; or an uncorrectable multiple error. A freshly erased page, where every data and ECC byte is 0xFF, gives a fixed all-ones location together with the multiple-error flag, so software can tell an erased page from a damaged one.

Software drives the engine through five word registers: control (0x00), mode (0x04), status (0x08), parity (0x0C) and complementary parity (0x10).

Top module: `ecc_page_engine`

## Requirements
- R1: After reset, the mode, status, parity and complementary parity registers all read zero.
- R2: Writing 1 to bit 0 at offset 0x00 clears the running parity, the word and ECC counters and the status snapshot. After that write, status and parity read zero.
- R3: Bits [1:0] at offset 0x04 set the data length: DATA_BASE bytes shifted left by that value. With the default of 512, that gives 512, 1024, 2048 or 4096 bytes, which is 528, 1056, 2112 or 4224 bytes with spare. Bit 4 selects the 16-bit bus. Both fields read back.
- R4: Until the code is captured, parity[15:4] holds the XOR of the word index of every set data bit and parity[3:0] holds the XOR of their bit indices. The complementary register holds the same XORs taken over the inverted indices, masked to the address bits in use.
- R5: The ECC words that follow the last data word are captured as the stored code. On the 8-bit bus the four bytes are parity low, parity high, complementary low, complementary high. On the 16-bit bus the two words are parity, then complementary.
- R6: Once capture ends, status (offset 0x08) reads 0 when the syndrome is zero. For one flipped data bit it reads 1 (bit 0), with parity[3:0] giving the bit index and parity[15:4] the word index.
- R7: A single flipped bit anywhere in the 32 stored code bits gives status 3 (bits 0 and 1).
- R8: Two data bits flipped give status 5 (bits 0 and 2). An erased page (all 0xFF, including the code) gives status 5 with parity[15:0] = 0xFFFF.
- R9: After capture, the status and parity readings stay fixed, and further data words are ignored until the next clear.
- R10: On the 8-bit bus, data_i[15:8] has no effect and bit indices run 0 to 7. On the 16-bit bus, word indices count 16-bit words.
- R11: Before capture completes, status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| data_valid_i | input | 1 | A NAND word is on data_i this cycle |
| data_i | input | 16 | NAND word; only bits [7:0] are used on the 8-bit bus |

## Verification
The bench builds the engine with DATA_BASE = 64, which keeps every one of the four length selects within a few hundred cycles on both bus widths. All eight length and width combinations are therefore covered, each with random data, a single data-bit flip, a flipped code bit, a double flip and the erased-page signature. WADDR_W stays at 12, so the full 16-bit parity layout, and the 0xFFF word field of the erased signature, are the same as in the default build.

// File: rtl/ecc_page_pkg.sv
package ecc_page_pkg;
  localparam logic [4:0] OFF_CTRL = 5'h00;
  localparam logic [4:0] OFF_MODE = 5'h04;
  localparam logic [4:0] OFF_STAT = 5'h08;
  localparam logic [4:0] OFF_PAR  = 5'h0C;
  localparam logic [4:0] OFF_NPAR = 5'h10;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_ECC  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/ecc_word_term.sv
// Parity contribution of one bus word at word index widx_i.
module ecc_word_term #(
  parameter int WADDR_W = 12,
  localparam int PAR_W = WADDR_W + 4
) (
  input  logic [15:0]      data_i,
  input  logic             wide_i,
  input  logic [WADDR_W-1:0] widx_i,
  input  logic [WADDR_W-1:0] wmask_i,
  output logic [PAR_W-1:0] term_p_o,
  output logic [PAR_W-1:0] term_n_o
);
  logic [3:0] bmask;
  logic       odd;
  logic [3:0] bp, bn;

  assign bmask = wide_i ? 4'hF : 4'h7;

  always_comb begin
    odd = 1'b0;
    bp  = '0;
    bn  = '0;
    for (int i = 0; i < 16; i++) begin
      if ((i < 8 || wide_i) && data_i[i]) begin
        odd = ~odd;
        bp  = bp ^ 4'(i);
        bn  = bn ^ (~4'(i) & bmask);
      end
    end
  end

  assign term_p_o = {odd ? widx_i : '0, bp};
  assign term_n_o = {odd ? (~widx_i & wmask_i) : '0, bn};
endmodule

// File: rtl/ecc_syndrome_class.sv
// Classifies the syndrome pair: {multi, code_err, any}.
module ecc_syndrome_class #(
  parameter int PAR_W = 16
) (
  input  logic [PAR_W-1:0] syn_p_i,
  input  logic [PAR_W-1:0] syn_n_i,
  input  logic [PAR_W-1:0] amask_i,
  output logic [2:0]       flags_o
);
  logic zero, one_bit, data_err;

  assign zero     = ~|{syn_p_i, syn_n_i};
  assign one_bit  = $countones({syn_p_i, syn_n_i}) == 1;
  assign data_err = (syn_p_i ^ syn_n_i) == amask_i;

  assign flags_o[0] = ~zero;
  assign flags_o[1] = one_bit;
  assign flags_o[2] = ~zero & ~one_bit & ~data_err;
endmodule

// File: rtl/ecc_page_engine.sv
module ecc_page_engine #(
  parameter int DATA_BASE = 512,
  parameter int WADDR_W   = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        data_valid_i,
  input  logic [15:0] data_i
);
  import ecc_page_pkg::*;

  localparam int PAR_W   = WADDR_W + 4;
  localparam int BASE_LG = $clog2(DATA_BASE);

  phase_e             phase_q;
  logic [1:0]         mode_q;
  logic               wide_q;
  logic [WADDR_W-1:0] word_cnt_q;
  logic [1:0]         ecc_cnt_q;
  logic [PAR_W-1:0]   acc_p_q, acc_n_q, sto_p_q, sto_n_q;

  logic               clr, mode_wr, ecc_last, done;
  logic [WADDR_W-1:0] wmask;
  logic [PAR_W-1:0]   amask, term_p, term_n, syn_p, syn_n, par_out, npar_out;
  logic [2:0]         flags, status;
  int unsigned        wbits;

  assign clr     = reg_we_i && reg_addr_i == OFF_CTRL && reg_wdata_i[0];
  assign mode_wr = reg_we_i && reg_addr_i == OFF_MODE;

  always_comb begin
    wbits = BASE_LG + int'(mode_q) - int'(wide_q);
    wmask = WADDR_W'((32'd1 << wbits) - 32'd1);
  end

  assign amask    = {wmask, wide_q ? 4'hF : 4'h7};
  assign ecc_last = wide_q ? (ecc_cnt_q == 2'd1) : (ecc_cnt_q == 2'd3);
  assign done     = phase_q == PH_DONE;

  ecc_word_term #(.WADDR_W(WADDR_W)) u_term (
    .data_i  (data_i),
    .wide_i  (wide_q),
    .widx_i  (word_cnt_q),
    .wmask_i (wmask),
    .term_p_o(term_p),
    .term_n_o(term_n)
  );

  assign syn_p = sto_p_q ^ acc_p_q;
  assign syn_n = sto_n_q ^ acc_n_q;

  ecc_syndrome_class #(.PAR_W(PAR_W)) u_class (
    .syn_p_i(syn_p),
    .syn_n_i(syn_n),
    .amask_i(amask),
    .flags_o(flags)
  );

  assign status   = done ? flags : 3'b000;
  assign par_out  = done ? syn_p : acc_p_q;
  assign npar_out = done ? syn_n : acc_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      wide_q <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= reg_wdata_i[1:0];
      wide_q <= reg_wdata_i[4];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_DATA;
      word_cnt_q <= '0;
      ecc_cnt_q  <= '0;
      acc_p_q    <= '0;
      acc_n_q    <= '0;
      sto_p_q    <= '0;
      sto_n_q    <= '0;
    end else if (clr) begin
      phase_q    <= PH_DATA;
      word_cnt_q <= '0;
      ecc_cnt_q  <= '0;
      acc_p_q    <= '0;
      acc_n_q    <= '0;
      sto_p_q    <= '0;
      sto_n_q    <= '0;
    end else if (data_valid_i) begin
      unique case (phase_q)
        PH_DATA: begin
          acc_p_q    <= acc_p_q ^ term_p;
          acc_n_q    <= acc_n_q ^ term_n;
          word_cnt_q <= word_cnt_q + 1'b1;
          if (word_cnt_q == wmask) begin
            phase_q   <= PH_ECC;
            ecc_cnt_q <= '0;
          end
        end
        PH_ECC: begin
          if (wide_q) begin
            if (ecc_cnt_q[0]) sto_n_q[15:0] <= data_i;
            else              sto_p_q[15:0] <= data_i;
          end else begin
            unique case (ecc_cnt_q)
              2'd0: sto_p_q[7:0]  <= data_i[7:0];
              2'd1: sto_p_q[15:8] <= data_i[7:0];
              2'd2: sto_n_q[7:0]  <= data_i[7:0];
              default: sto_n_q[15:8] <= data_i[7:0];
            endcase
          end
          ecc_cnt_q <= ecc_cnt_q + 1'b1;
          if (ecc_last) phase_q <= PH_DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_MODE: reg_rdata_o = {27'd0, wide_q, 2'b00, mode_q};
      OFF_STAT: reg_rdata_o = {29'd0, status};
      OFF_PAR:  reg_rdata_o = 32'(par_out);
      OFF_NPAR: reg_rdata_o = 32'(npar_out);
      default:  reg_rdata_o = '0;
    endcase
  end

  // R2: a clear returns the engine to the start of a page
  a_r2_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (phase_q == PH_DATA && word_cnt_q == '0 && acc_p_q == '0 && acc_n_q == '0));

  // R9: the snapshot holds while nothing clears it or changes the mode
  a_r9_snapshot_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !clr && !mode_wr) |=> (done && $stable(status) && $stable(par_out) && $stable(npar_out)));

  // R8: code error and multiple error never coexist
  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status[2:1]));

  // R5: the snapshot only follows the code capture phase
  a_r5_capture_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $past(phase_q == PH_ECC));
endmodule

// File: tb/ecc_page_engine_tb.sv
module ecc_page_engine_tb;
  localparam int BASE = 64;
  localparam logic [4:0] A_CTRL = 5'h00, A_MODE = 5'h04, A_STAT = 5'h08,
                         A_PAR = 5'h0C, A_NPAR = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dvalid = 1'b0;
  logic [15:0] dword = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] pg [512];

  always #2 clk = ~clk;

  ecc_page_engine #(.DATA_BASE(BASE), .WADDR_W(12)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .data_valid_i(dvalid), .data_i(dword)
  );

  function automatic int nwords(int mode, bit wide);
    return (BASE << mode) >> wide;
  endfunction

  function automatic logic [31:0] calc_code(int mode, bit wide);
    logic [15:0] p = '0, n = '0, am;
    int wbits = $clog2(BASE) + mode - int'(wide);
    logic [11:0] wm = 12'((1 << wbits) - 1);
    am = {wm, wide ? 4'hF : 4'h7};
    for (int w = 0; w < nwords(mode, wide); w++)
      for (int b = 0; b < (wide ? 16 : 8); b++)
        if (pg[w][b]) begin
          p ^= {12'(w), 4'(b)};
          n ^= ~{12'(w), 4'(b)} & am;
        end
    return {n, p};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic put(input logic [15:0] d);
    @(negedge clk);
    dvalid = 1'b1; dword = d;
  endtask

  task automatic idle();
    @(negedge clk);
    dvalid = 1'b0;
  endtask

  task automatic start(input int mode, input bit wide);
    wr(A_MODE, {27'd0, wide, 2'b00, 2'(mode)});
    wr(A_CTRL, 32'd1);
  endtask

  task automatic send_page(input int mode, input bit wide, input bit send_ecc,
                           input logic [15:0] ep, input logic [15:0] en);
    for (int w = 0; w < nwords(mode, wide); w++) put(pg[w]);
    if (send_ecc) begin
      if (wide) begin
        put(ep); put(en);
      end else begin
        put({8'($urandom), ep[7:0]}); put({8'($urandom), ep[15:8]});
        put({8'($urandom), en[7:0]}); put({8'($urandom), en[15:8]});
      end
    end
    idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, code;
    logic [15:0] cp, cn;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rd(A_MODE, v); chk("R1 mode", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_PAR, v);  chk("R1 parity", v, 0);
    rd(A_NPAR, v); chk("R1 nparity", v, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int wi = 0; wi < 2; wi++) begin
      for (int mode = 0; mode < 4; mode++) begin
        bit wide = bit'(wi);
        int nw = nwords(mode, wide);
        int bw = wide ? 16 : 8;
        int w1, b1, w2, b2, eb;
        for (int w = 0; w < nw; w++) pg[w] = 16'($urandom);
        code = calc_code(mode, wide);
        cp = code[15:0]; cn = code[31:16];

        // write pass: code only, upper byte garbage on narrow bus
        start(mode, wide);
        rd(A_MODE, v); chk("R3 mode readback", v, {27'd0, wide, 2'b00, 2'(mode)});
        send_page(mode, wide, 1'b0, 16'h0, 16'h0);
        rd(A_PAR, v);  chk("R4/R10 parity", v, {16'd0, cp});
        rd(A_NPAR, v); chk("R4/R10 nparity", v, {16'd0, cn});
        rd(A_STAT, v); chk("R11 status before capture", v, 0);

        // clean read
        start(mode, wide);
        send_page(mode, wide, 1'b1, cp, cn);
        rd(A_STAT, v); chk("R5/R6 clean status", v, 0);
        rd(A_PAR, v);  chk("R5/R6 clean syndrome", v, 0);

        // single data bit
        w1 = $urandom_range(nw - 1); b1 = $urandom_range(bw - 1);
        pg[w1][b1] = ~pg[w1][b1];
        start(mode, wide);
        send_page(mode, wide, 1'b1, cp, cn);
        pg[w1][b1] = ~pg[w1][b1];
        rd(A_STAT, v); chk("R6 single data status", v, 1);
        rd(A_PAR, v);  chk("R6 error location", v, {16'd0, 12'(w1), 4'(b1)});

        // single code bit
        eb = $urandom_range(31);
        start(mode, wide);
        if (eb < 16) send_page(mode, wide, 1'b1, cp ^ (16'd1 << eb), cn);
        else         send_page(mode, wide, 1'b1, cp, cn ^ (16'd1 << (eb - 16)));
        rd(A_STAT, v); chk("R7 code bit status", v, 3);

        // double data error
        w2 = (w1 + 1 + $urandom_range(nw - 2)) % nw; b2 = $urandom_range(bw - 1);
        pg[w1][b1] = ~pg[w1][b1]; pg[w2][b2] = ~pg[w2][b2];
        start(mode, wide);
        send_page(mode, wide, 1'b1, cp, cn);
        pg[w1][b1] = ~pg[w1][b1]; pg[w2][b2] = ~pg[w2][b2];
        rd(A_STAT, v); chk("R8 double status", v, 5);
        rd(A_PAR, code);
        for (int k = 0; k < 5; k++) put(16'($urandom));
        idle();
        rd(A_STAT, v); chk("R9 status after extra words", v, 5);
        rd(A_PAR, v);  chk("R9 parity after extra words", v, code);

        // clear
        wr(A_CTRL, 32'd1);
        rd(A_STAT, v); chk("R2 status after clear", v, 0);
        rd(A_PAR, v);  chk("R2 parity after clear", v, 0);
      end
    end

    // erased pages
    for (int k = 0; k < 2; k++) begin
      int mode = k ? 3 : 0;
      bit wide = bit'(k);
      for (int w = 0; w < 512; w++) pg[w] = 16'hFFFF;
      start(mode, wide);
      send_page(mode, wide, 1'b1, 16'hFFFF, 16'hFFFF);
      rd(A_STAT, v); chk("R8 erased status", v, 5);
      rd(A_PAR, v);  chk("R8 erased signature", v, 32'h0000FFFF);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule